// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block is the receiving half of a serial link in which a remote transmitter drives both the shift clock and the data line. The block brings the external clock and data into the system clock domain through flop synchronizers. A rising edge of the synchronized clock shifts one data bit into an 8-bit frame, least significant bit first. Because the shift clock comes from the sender, nothing arrives unless the remote transmitter is running.

When a frame is complete, it is copied into a holding buffer that the processor reads. A full flag reports that the buffer holds unread data, and a one-cycle interrupt request marks each time that flag becomes set. An overrun flag records that a frame replaced unread data. A ready line, active low, tells the sender when the receiver can accept a frame. Reading the buffer clears the status flags.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `rd_data` is 0, `rx_full`, `overrun` and `rx_irq` are 0, and `rdy_n` is 1.
- R2: While `rx_en` is 0, clock edges on `ext_sclk` shift nothing in: `rx_full` stays 0, `rx_irq` stays 0 and `rdy_n` stays 1.
- R3: Each rising edge of `ext_sclk` takes one bit from `ext_rxd`. The first bit received lands in `rd_data[0]` and the eighth in `rd_data[7]`. The synchronized edge detect gives one shift per external edge.
- R4: `rdy_n` is 0 while `rx_en` is 1 and no frame is in progress. It is 1 from the first bit of a frame until all 8 bits have arrived, and then returns to 0.
- R5: `rx_irq` is high for exactly one cycle each time `rx_full` changes from 0 to 1, and at no other time.
- R6: When a frame completes while `rx_full` is already 1, `overrun` is set and `rd_data` takes the new frame.
- R7: A one-cycle pulse on `rd_lo` clears both `rx_full` and `overrun`.
- R8: Setting `rx_en` to 0 clears `overrun`. It also discards any partly received frame, so the next frame starts again from bit 0.
- R9: `frame_err`, `parity_err` and `err_sum` are always 0.
- R10: `rx_full` and `rd_data` update on the third rising edge of `clk` after the rising edge of `ext_sclk` that carries the eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable |
| ext_sclk | input | 1 | External shift clock from the remote transmitter |
| ext_rxd | input | 1 | Serial data input |
| rd_lo | input | 1 | One-cycle strobe: the low byte of the buffer is being read |
| rd_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread frame |
| overrun | output | 1 | A frame overwrote unread data |
| frame_err | output | 1 | Framing error flag, fixed at 0 |
| parity_err | output | 1 | Parity error flag, fixed at 0 |
| err_sum | output | 1 | Error summary flag, fixed at 0 |
| rdy_n | output | 1 | Ready to receive, active low |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
Each external clock edge passes through two synchronizer flops and one shift stage. The buffer, `rx_full` and `rx_irq` therefore change on the third system clock edge after the eighth rising edge of `ext_sclk`, and `rdy_n` goes high on that same third edge after the first bit. The bench holds each half of the external clock for four system cycles, changes data only while the clock is low, and samples on falling edges of `clk` at least four cycles after the edge in question, so every result has settled. `rd_lo` and `rx_en` act on the next clock edge, and the bench checks them one full cycle later.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
    localparam int unsigned SYNC_MIN   = 2;

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [CNT_W-1:0]      bitcnt_t;

    typedef struct packed {
        logic full;
        logic ovr;
    } rx_flags_t;

    localparam rx_flags_t FLAGS_CLEAR = '{full: 1'b0, ovr: 1'b0};

    function automatic logic is_last_bit(input bitcnt_t c);
        return c == bitcnt_t'(FRAME_BITS - 1);
    endfunction

    function automatic frame_t push_msb(input frame_t cur, input logic b);
        return {b, cur[FRAME_BITS-1:1]};
    endfunction

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic data_in,
    output logic edge_stb,
    output logic data_out
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_prev;

    generate
        if (STAGES < ssrx_pkg::SYNC_MIN) begin : g_bad
            initial $error("ssrx_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_pipe <= '0;
            dat_pipe <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-2:0], sclk_in};
            dat_pipe <= {dat_pipe[STAGES-2:0], data_in};
            clk_prev <= clk_pipe[STAGES-1];
        end
    end

    assign edge_stb = clk_pipe[STAGES-1] & ~clk_prev;
    assign data_out = dat_pipe[STAGES-1];

    p_edge_single_r3: assert property (@(posedge clk) disable iff (rst)
        edge_stb |=> !edge_stb);

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift
    import ssrx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   bit_stb,
    input  logic   bit_val,
    output logic   done,
    output frame_t frame_next,
    output logic   busy
);
    frame_t  sh_q;
    bitcnt_t cnt_q;

    assign frame_next = push_msb(sh_q, bit_val);
    assign done       = en & bit_stb & is_last_bit(cnt_q);
    assign busy       = cnt_q != '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (bit_stb) begin
            sh_q  <= frame_next;
            cnt_q <= is_last_bit(cnt_q) ? '0 : cnt_q + 1'b1;
        end
    end

    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_stb && $past(en)) |=> $stable(cnt_q) || !en);

endmodule

// File: rtl/ssrx_status.sv
module ssrx_status
    import ssrx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   done,
    input  frame_t frame_in,
    input  logic   busy,
    input  logic   rd_lo,
    output frame_t buf_out,
    output logic   full,
    output logic   ovr,
    output logic   irq,
    output logic   rdy_n
);
    rx_flags_t fl_q, fl_d;
    frame_t    buf_q;
    logic      irq_q;

    always_comb begin
        fl_d = fl_q;
        if (rd_lo) begin
            fl_d = FLAGS_CLEAR;
        end
        if (!en) begin
            fl_d.ovr = 1'b0;
        end
        if (done) begin
            fl_d.full = 1'b1;
            if (fl_q.full && !rd_lo) begin
                fl_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= FLAGS_CLEAR;
            buf_q <= '0;
            irq_q <= 1'b0;
        end else begin
            fl_q  <= fl_d;
            irq_q <= fl_d.full & ~fl_q.full;
            if (done) begin
                buf_q <= frame_in;
            end
        end
    end

    assign buf_out = buf_q;
    assign full    = fl_q.full;
    assign ovr     = fl_q.ovr;
    assign irq     = irq_q;
    assign rdy_n   = ~en | busy;

    p_irq_on_set_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> full && !$past(full));

    p_ovr_needs_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> full);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !done) |=> !full && !ovr);

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ovr);

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssrx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       ext_sclk,
    input  logic       ext_rxd,
    input  logic       rd_lo,
    output logic [7:0] rd_data,
    output logic       rx_full,
    output logic       overrun,
    output logic       frame_err,
    output logic       parity_err,
    output logic       err_sum,
    output logic       rdy_n,
    output logic       rx_irq
);
    logic   edge_stb;
    logic   bit_val;
    logic   done;
    logic   busy;
    frame_t frame_next;
    frame_t buf_q;

    ssrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sclk_in  (ext_sclk),
        .data_in  (ext_rxd),
        .edge_stb (edge_stb),
        .data_out (bit_val)
    );

    ssrx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .bit_stb    (edge_stb),
        .bit_val    (bit_val),
        .done       (done),
        .frame_next (frame_next),
        .busy       (busy)
    );

    ssrx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en),
        .done     (done),
        .frame_in (frame_next),
        .busy     (busy),
        .rd_lo    (rd_lo),
        .buf_out  (buf_q),
        .full     (rx_full),
        .ovr      (overrun),
        .irq      (rx_irq),
        .rdy_n    (rdy_n)
    );

    assign rd_data    = buf_q;
    assign frame_err  = 1'b0;
    assign parity_err = 1'b0;
    assign err_sum    = 1'b0;

endmodule

// File: tb/sim_sync_serial_rx.sv
module sim_sync_serial_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       ext_sclk = 1'b1;
    logic       ext_rxd = 1'b0;
    logic       rd_lo = 1'b0;
    logic [7:0] rd_data;
    logic       rx_full, overrun, frame_err, parity_err, err_sum, rdy_n, rx_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_rx u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ext_sclk(ext_sclk),
        .ext_rxd(ext_rxd), .rd_lo(rd_lo), .rd_data(rd_data),
        .rx_full(rx_full), .overrun(overrun), .frame_err(frame_err),
        .parity_err(parity_err), .err_sum(err_sum), .rdy_n(rdy_n),
        .rx_irq(rx_irq)
    );

    always @(posedge clk) if (!rst && rx_irq) irq_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            ext_sclk = 1'b0;
            ext_rxd  = v[i];
            wait_n(HALF_SCLK);
            ext_sclk = 1'b1;
            wait_n(HALF_SCLK);
        end
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        wait_n(1);
    endtask

    task automatic check_errs();
        chk({frame_err, parity_err, err_sum} == 3'b000, "R9 error flags",
            int'({frame_err, parity_err, err_sum}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ic;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(!rx_full && !overrun && !rx_irq, "R1 flags",
            int'({rx_full, overrun, rx_irq}), 0);
        chk(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
        check_errs();

        // R2 disabled: a full frame is ignored
        send_bits(8'hA5, 8);
        wait_n(4);
        chk(!rx_full, "R2 full while disabled", rx_full, 0);
        chk(irq_cnt == 0, "R2 irq while disabled", irq_cnt, 0);
        chk(rdy_n == 1'b1, "R2 rdy_n while disabled", rdy_n, 1);

        @(negedge clk);
        rx_en = 1'b1;
        wait_n(1);
        chk(rdy_n == 1'b0, "R4 rdy_n after enable", rdy_n, 0);

        // R4 busy during frame
        send_bits(8'h3C, 1);
        chk(rdy_n == 1'b1, "R4 rdy_n mid-frame", rdy_n, 1);
        send_bits(8'h3C >> 1, 7);
        wait_n(4);
        chk(rd_data == 8'h3C, "R3 first frame", rd_data, 8'h3C);
        chk(rdy_n == 1'b0, "R4 rdy_n after frame", rdy_n, 0);
        chk(irq_cnt == 1, "R5 irq once", irq_cnt, 1);
        do_read();
        chk(!rx_full, "R7 read clears full", rx_full, 0);

        // R10 latency: third clock edge after the eighth external rise
        send_bits(8'h81, 7);
        @(negedge clk);
        ext_sclk = 1'b0;
        ext_rxd  = 1'b1;
        wait_n(HALF_SCLK);
        ext_sclk = 1'b1;
        wait_n(2);
        chk(!rx_full, "R10 full not yet at edge 2", rx_full, 0);
        wait_n(1);
        chk(rx_full && rd_data == 8'h81, "R10 full at edge 3", rd_data, 8'h81);
        wait_n(2);
        do_read();

        // R3/R5/R7 exhaustive sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            ic = irq_cnt;
            send_bits(8'(v), 8);
            wait_n(2);
            chk(rd_data == 8'(v), "R3 sweep data", rd_data, v);
            chk(rx_full && !overrun, "R6 sweep flags", int'({rx_full, overrun}), 2);
            chk(irq_cnt == ic + 1, "R5 sweep irq", irq_cnt - ic, 1);
            do_read();
            chk(!rx_full && !overrun, "R7 sweep read", int'({rx_full, overrun}), 0);
            check_errs();
        end

        // R6 overrun: two frames without a read
        ic = irq_cnt;
        send_bits(8'h11, 8);
        send_bits(8'hE7, 8);
        wait_n(3);
        chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
        chk(rd_data == 8'hE7, "R6 newest frame kept", rd_data, 8'hE7);
        chk(irq_cnt == ic + 1, "R5 no irq on overrun", irq_cnt - ic, 1);
        check_errs();
        do_read();
        chk(!overrun && !rx_full, "R7 read clears overrun",
            int'({rx_full, overrun}), 0);

        // R8 disable clears overrun
        send_bits(8'h01, 8);
        send_bits(8'h02, 8);
        wait_n(3);
        chk(overrun == 1'b1, "R6 overrun again", overrun, 1);
        @(negedge clk);
        rx_en = 1'b0;
        wait_n(1);
        chk(overrun == 1'b0, "R8 disable clears overrun", overrun, 0);
        chk(rx_full == 1'b1, "R8 full kept on disable", rx_full, 1);
        @(negedge clk);
        rx_en = 1'b1;
        do_read();

        // R8 partial frame discarded
        send_bits(8'hFF, 4);
        @(negedge clk);
        rx_en = 1'b0;
        wait_n(1);
        chk(rdy_n == 1'b1, "R8 rdy_n when disabled", rdy_n, 1);
        @(negedge clk);
        rx_en = 1'b1;
        wait_n(1);
        chk(rdy_n == 1'b0, "R8 rdy_n ready after re-enable", rdy_n, 0);
        send_bits(8'h5A, 8);
        wait_n(3);
        chk(rd_data == 8'h5A, "R8 fresh frame after discard", rd_data, 8'h5A);
        chk(rx_full && !overrun, "R8 flags after discard", int'({rx_full, overrun}), 2);
        do_read();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule